// File: doc/BRIEF.md
# CPU Operating Mode Controller

This block is the piece of a processor core that holds the control bits governing the operating mode and works out from them which mode the core runs in. It keeps five things. The first is a control word with a protection enable bit and a paging enable bit. The second is an extension word with the physical-address-extension bit. The third is a page-root pointer. The fourth is a feature word with a long-mode enable bit and a long-mode active bit. The fifth is a cached long flag from the current code segment. Software-side logic issues one register write per cycle. The controller validates each write against the current state, then either commits it or turns it away with a fault.

Long mode is entered in one sequence. Protection is already on, address extension is on and long-mode enable is set; then paging is switched from off to on. At that moment the hardware sets the long-mode active bit. The same paging write is refused in two cases: protection is off in the written value, or address extension is off. Changing long-mode enable while paging is on is also refused. The controller reports four things: the derived mode code, the paging-structure depth, a one-cycle fault pulse with a cause code, and the page-table base. The write port carries no back-pressure. A request presented with `wr_valid` high is taken on that clock edge, whatever it asks for.

Top module: `cpu_mode_ctrl`

## Requirements
- R1: After reset every control bit, the root pointer and both feature bits are 0, so `mode_o`=0, `depth_o`=0, `pt_base_o`=0 and `fault_o`=0.
- R2: Encodings. `wr_sel` 0 selects the control word (bit 0 protection, bit 1 paging), 1 the extension word (bit 0 address extension), 2 the root pointer, 3 the feature word (bit 0 long-mode enable, bit 1 long-mode active), and 4 the code-segment flag (bit 0 long flag). Codes 5 to 7 do nothing. `mode_o` codes are: real 0, protected unpaged 1, 32-bit paging 2, extended 32-bit paging 3, compatibility 4, 64-bit 5.
- R3: A control write that turns paging from 0 to 1 while long-mode enable is 1, with protection and extension both on, sets long-mode active on the same edge.
- R4: That activating write with extension off is refused. The state is unchanged and a fault with cause 2 (extension off) is raised.
- R5: That activating write with protection 0 in the written value is refused with cause 1 (protection off). This cause wins when extension is also off.
- R6: Paging on with long-mode active 0 gives mode 2 with depth 2, or mode 3 with depth 3 when extension is on.
- R7: With long-mode active, `depth_o` is 4, or 5 when `five_lvl_en` is 1. Whenever paging and protection are on, `pt_base_o` is the loaded root pointer with its low `PAGE_SHIFT` bits cleared. Otherwise it is 0.
- R8: With long-mode active, the mode is 5 if the code-segment long flag is 1 and 4 if it is 0.
- R9: Bit 1 of a feature-word write is ignored. Long-mode active changes only through paging writes.
- R10: While paging is on, a feature write that would change long-mode enable is refused with cause 3 and leaves the bit unchanged. Rewriting the same value is accepted.
- R11: A control write that clears paging clears long-mode active on the same edge.
- R12: `fault_o` is high only in the cycle after a refused write. `fault_cause_o` is nonzero exactly when `fault_o` is high. An accepted write or an idle cycle gives `fault_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request, taken on the clock edge |
| wr_sel | input | 3 | Target register code |
| wr_data | input | DATA_W | Write value |
| five_lvl_en | input | 1 | Selects five-level tables in long mode |
| mode_o | output | 3 | Derived operating mode code |
| depth_o | output | 3 | Paging structure depth, 0 when unpaged |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_cause_o | output | 2 | Fault cause: 1 protection off, 2 extension off, 3 enable changed while paging |
| pt_base_o | output | ADDR_W | Page-table base in use |

## Verification
The assertions check several rules on every cycle. A fault pulse only follows a write, and the mode does not move across a refused write. Long-mode active implies paging and a depth of 4 or 5. Long-mode active rises only on a control write. Mode 5 needs the long flag. The bench scenarios show the rest: the exact orderings that activate or refuse long mode, the priority between the two paging causes, the fact that refused or ignored writes leave the state alone (seen later through the mode a paging write produces), the masked page-table base, and the reset values.

// File: rtl/cpu_mode_pkg.sv
package cpu_mode_pkg;

  typedef enum logic [2:0] {
    MODE_REAL    = 3'd0,
    MODE_PROT    = 3'd1,
    MODE_PG32    = 3'd2,
    MODE_PGEXT   = 3'd3,
    MODE_COMPAT  = 3'd4,
    MODE_LONG64  = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_PROT   = 2'd1,
    CAUSE_EXT    = 2'd2,
    CAUSE_ENCHG  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    SEL_CTL  = 3'd0,
    SEL_EXT  = 3'd1,
    SEL_ROOT = 3'd2,
    SEL_FEAT = 3'd3,
    SEL_CODE = 3'd4
  } sel_e;

  // bit positions inside each write word
  localparam int unsigned BIT_PROT  = 0;
  localparam int unsigned BIT_PAGE  = 1;
  localparam int unsigned BIT_EXT   = 0;
  localparam int unsigned BIT_LMEN  = 0;
  localparam int unsigned BIT_LMACT = 1;
  localparam int unsigned BIT_LFLAG = 0;

  typedef struct packed {
    logic prot;    // protection enable
    logic page;    // paging enable
    logic ext;     // physical address extension
    logic lm_en;   // long-mode enable
    logic lm_act;  // long-mode active (hardware owned)
    logic cs_long; // cached code-segment long flag
  } ctl_state_t;

  localparam ctl_state_t STATE_RESET = '0;

endpackage

// File: rtl/cpu_mode_wr_check.sv
module cpu_mode_wr_check
  import cpu_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  ctl_state_t        st,
  input  logic              wr_valid,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_state_t        st_nxt,
  output logic              root_load,
  output logic              err,
  output cause_e            cause
);

  logic new_prot, new_page, new_ext, new_lmen, new_lflag;
  logic activating;

  assign new_prot   = wr_data[BIT_PROT];
  assign new_page   = wr_data[BIT_PAGE];
  assign new_ext    = wr_data[BIT_EXT];
  assign new_lmen   = wr_data[BIT_LMEN];
  assign new_lflag  = wr_data[BIT_LFLAG];

  // paging switched on while long mode is enabled
  assign activating = new_page && !st.page && st.lm_en;

  always_comb begin
    st_nxt    = st;
    root_load = 1'b0;
    err       = 1'b0;
    cause     = CAUSE_NONE;
    if (wr_valid) begin
      case (sel_e'(wr_sel))
        SEL_CTL: begin
          if (activating && !new_prot) begin
            err   = 1'b1;
            cause = CAUSE_PROT;
          end else if (activating && !st.ext) begin
            err   = 1'b1;
            cause = CAUSE_EXT;
          end else begin
            st_nxt.prot = new_prot;
            st_nxt.page = new_page;
            if (!new_page) begin
              st_nxt.lm_act = 1'b0;
            end else if (activating) begin
              st_nxt.lm_act = 1'b1;
            end
          end
        end
        SEL_EXT: begin
          st_nxt.ext = new_ext;
        end
        SEL_ROOT: begin
          root_load = 1'b1;
        end
        SEL_FEAT: begin
          // the active bit in the written word is never looked at
          if (st.page && (new_lmen != st.lm_en)) begin
            err   = 1'b1;
            cause = CAUSE_ENCHG;
          end else begin
            st_nxt.lm_en = new_lmen;
          end
        end
        SEL_CODE: begin
          st_nxt.cs_long = new_lflag;
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/cpu_mode_state.sv
module cpu_mode_state
  import cpu_mode_pkg::*;
#(
  parameter int unsigned ROOT_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_t        st_nxt,
  input  logic              root_load,
  input  logic [ROOT_W-1:0] root_nxt,
  input  logic              err,
  input  cause_e            cause,
  output ctl_state_t        st_q,
  output logic [ROOT_W-1:0] root_q,
  output logic              fault_q,
  output cause_e            cause_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= STATE_RESET;
      root_q  <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      st_q    <= st_nxt;
      if (root_load) begin
        root_q <= root_nxt;
      end
      fault_q <= err;
      cause_q <= err ? cause : CAUSE_NONE;
    end
  end

endmodule

// File: rtl/cpu_mode_decode.sv
module cpu_mode_decode
  import cpu_mode_pkg::*;
#(
  parameter int unsigned ADDR_W     = 52,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  ctl_state_t                   st,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] root,
  input  logic                         five_lvl_en,
  output mode_e                        mode,
  output logic [2:0]                   depth,
  output logic [ADDR_W-1:0]            base
);

  localparam logic [2:0] DEPTH_NONE  = 3'd0;
  localparam logic [2:0] DEPTH_LEG   = 3'd2;
  localparam logic [2:0] DEPTH_LEGX  = 3'd3;
  localparam logic [2:0] DEPTH_LONG4 = 3'd4;
  localparam logic [2:0] DEPTH_LONG5 = 3'd5;

  logic paged;
  assign paged = st.prot && st.page;

  always_comb begin
    mode  = MODE_REAL;
    depth = DEPTH_NONE;
    if (!st.prot) begin
      mode = MODE_REAL;
    end else if (!st.page) begin
      mode = MODE_PROT;
    end else if (st.lm_act) begin
      mode  = st.cs_long ? MODE_LONG64 : MODE_COMPAT;
      depth = five_lvl_en ? DEPTH_LONG5 : DEPTH_LONG4;
    end else if (st.ext) begin
      mode  = MODE_PGEXT;
      depth = DEPTH_LEGX;
    end else begin
      mode  = MODE_PG32;
      depth = DEPTH_LEG;
    end
  end

  assign base = paged ? {root, {PAGE_SHIFT{1'b0}}} : '0;

endmodule

// File: rtl/cpu_mode_ctrl.sv
module cpu_mode_ctrl
  import cpu_mode_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned ADDR_W     = 52,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              five_lvl_en,
  output logic [2:0]        mode_o,
  output logic [2:0]        depth_o,
  output logic              fault_o,
  output logic [1:0]        fault_cause_o,
  output logic [ADDR_W-1:0] pt_base_o
);

  localparam int unsigned ROOT_W = ADDR_W - PAGE_SHIFT;

  ctl_state_t        st_q, st_nxt;
  logic              root_load, err, fault_q;
  cause_e            cause, cause_q;
  logic [ROOT_W-1:0] root_q;
  mode_e             mode;

  cpu_mode_wr_check #(.DATA_W(DATA_W)) u_check (
    .st        (st_q),
    .wr_valid  (wr_valid),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .st_nxt    (st_nxt),
    .root_load (root_load),
    .err       (err),
    .cause     (cause)
  );

  cpu_mode_state #(.ROOT_W(ROOT_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_nxt    (st_nxt),
    .root_load (root_load),
    .root_nxt  (wr_data[ADDR_W-1:PAGE_SHIFT]),
    .err       (err),
    .cause     (cause),
    .st_q      (st_q),
    .root_q    (root_q),
    .fault_q   (fault_q),
    .cause_q   (cause_q)
  );

  cpu_mode_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_decode (
    .st          (st_q),
    .root        (root_q),
    .five_lvl_en (five_lvl_en),
    .mode        (mode),
    .depth       (depth_o),
    .base        (pt_base_o)
  );

  assign mode_o        = mode;
  assign fault_o       = fault_q;
  assign fault_cause_o = cause_q;

endmodule

// File: rtl/cpu_mode_ctrl_chk.sv
module cpu_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [2:0] wr_sel,
  input logic [2:0] mode_o,
  input logic [2:0] depth_o,
  input logic       fault_o,
  input logic [1:0] fault_cause_o,
  input logic       lm_act,
  input logic       page,
  input logic       cs_long
);

  // R12: a fault pulse only ever follows a write request
  a_r12_fault_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(wr_valid));

  // R12: cause is nonzero exactly while the pulse is high
  a_r12_cause_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (fault_cause_o != 2'd0));
  a_r12_cause_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> (fault_cause_o == 2'd0));

  // R4: a refused write leaves the mode where it was
  a_r4_mode_kept_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (mode_o == $past(mode_o)));

  // R11: long mode active never outlives paging
  a_r11_active_needs_paging: assert property (@(posedge clk) disable iff (!rst_n)
    lm_act |-> page);

  // R9: the active bit rises only on a control-word write
  a_r9_active_rises_on_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lm_act) |-> $past(wr_valid && (wr_sel == 3'd0)));

  // R8: 64-bit submode needs the long flag
  a_r8_sixtyfour_needs_l: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5) |-> (cs_long && lm_act));

  // R7: long-mode depth is four or five
  a_r7_long_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 || mode_o == 3'd5) |-> (depth_o == 3'd4 || depth_o == 3'd5));

  // R6: legacy paging depth matches its mode code
  a_r6_legacy_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 || mode_o == 3'd3) |-> (depth_o == mode_o));

endmodule

bind cpu_mode_ctrl cpu_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_sel        (wr_sel),
  .mode_o        (mode_o),
  .depth_o       (depth_o),
  .fault_o       (fault_o),
  .fault_cause_o (fault_cause_o),
  .lm_act        (st_q.lm_act),
  .page          (st_q.page),
  .cs_long       (st_q.cs_long)
);

// File: tb/cpu_mode_ctrl_bench.sv
module cpu_mode_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 52;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [2:0]        wr_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              five_lvl_en = 1'b0;
  logic [2:0]        mode_o, depth_o;
  logic              fault_o;
  logic [1:0]        fault_cause_o;
  logic [ADDR_W-1:0] pt_base_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_mode_ctrl u_cpu_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .five_lvl_en(five_lvl_en), .mode_o(mode_o),
    .depth_o(depth_o), .fault_o(fault_o), .fault_cause_o(fault_cause_o),
    .pt_base_o(pt_base_o)
  );

  // {req[3:0], sel[2:0], data[7:0], five, mode[2:0], depth[2:0], fault, cause[1:0]}
  typedef logic [24:0] vec_t;
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    {4'd2,  3'd0, 8'h01, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R2 protection on
    {4'd6,  3'd0, 8'h03, 1'b0, 3'd2, 3'd2, 1'b0, 2'd0}, // R6 32-bit paging
    {4'd10, 3'd3, 8'h01, 1'b0, 3'd2, 3'd2, 1'b1, 2'd3}, // R10 enable change refused
    {4'd2,  3'd0, 8'h01, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R2 paging off
    {4'd2,  3'd1, 8'h01, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R2 extension on
    {4'd10, 3'd0, 8'h03, 1'b0, 3'd3, 3'd3, 1'b0, 2'd0}, // R10 enable stayed 0, R6 ext paging
    {4'd11, 3'd0, 8'h01, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R11 paging off
    {4'd2,  3'd3, 8'h01, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R2 long-mode enable
    {4'd2,  3'd1, 8'h00, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R2 extension off
    {4'd4,  3'd0, 8'h03, 1'b0, 3'd1, 3'd0, 1'b1, 2'd2}, // R4 extension off refused
    {4'd5,  3'd0, 8'h02, 1'b0, 3'd1, 3'd0, 1'b1, 2'd1}, // R5 protection wins
    {4'd2,  3'd1, 8'h01, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R2 extension on
    {4'd5,  3'd0, 8'h02, 1'b0, 3'd1, 3'd0, 1'b1, 2'd1}, // R5 protection off
    {4'd3,  3'd0, 8'h03, 1'b0, 3'd4, 3'd4, 1'b0, 2'd0}, // R3 enter compatibility
    {4'd8,  3'd4, 8'h01, 1'b0, 3'd5, 3'd4, 1'b0, 2'd0}, // R8 64-bit
    {4'd7,  3'd4, 8'h01, 1'b1, 3'd5, 3'd5, 1'b0, 2'd0}, // R7 five levels
    {4'd10, 3'd3, 8'h03, 1'b0, 3'd5, 3'd4, 1'b0, 2'd0}, // R10 same value accepted
    {4'd10, 3'd3, 8'h00, 1'b0, 3'd5, 3'd4, 1'b1, 2'd3}, // R10 clear refused
    {4'd11, 3'd0, 8'h01, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R11 active cleared
    {4'd9,  3'd3, 8'h02, 1'b0, 3'd1, 3'd0, 1'b0, 2'd0}, // R9 active bit write
    {4'd9,  3'd0, 8'h03, 1'b0, 3'd3, 3'd3, 1'b0, 2'd0}  // R9 not long mode
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [DATA_W-1:0] data);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = sel;
    wr_data  = data;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", 64'(mode_o), 0);
    check("R1 depth", 64'(depth_o), 0);
    check("R1 fault", 64'(fault_o), 0);
    check("R1 base", 64'(pt_base_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      five_lvl_en = VECS[i][9];
      do_write(VECS[i][20:18], {56'd0, VECS[i][17:10]});
      check($sformatf("R%0d vec%0d mode", VECS[i][24:21], i), 64'(mode_o), 64'(VECS[i][8:6]));
      check($sformatf("R%0d vec%0d depth", VECS[i][24:21], i), 64'(depth_o), 64'(VECS[i][5:3]));
      check($sformatf("R%0d vec%0d fault", VECS[i][24:21], i), 64'(fault_o), 64'(VECS[i][2]));
      check($sformatf("R%0d vec%0d cause", VECS[i][24:21], i), 64'(fault_cause_o), 64'(VECS[i][1:0]));
    end

    // R7 page-table base masked, paging on (mode 3 now)
    do_write(3'd2, 64'h1234_5678_9ABC_DFFF);
    check("R7 base", 64'(pt_base_o), 64'h4_5678_9ABC_D000);
    // R12 fault pulse lasts one cycle
    do_write(3'd3, 64'h1);
    check("R12 fault high", 64'(fault_o), 1);
    @(posedge clk); #1;
    check("R12 fault drops", 64'(fault_o), 0);
    check("R12 cause drops", 64'(fault_cause_o), 0);
    // R2 unused selector code has no effect
    do_write(3'd6, 64'h0);
    check("R2 unused sel mode", 64'(mode_o), 3);
    // R7 base is zero when unpaged
    do_write(3'd0, 64'h1);
    check("R7 base unpaged", 64'(pt_base_o), 0);
    // enable long mode then reset mid-run
    do_write(3'd3, 64'h1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mode after reset", 64'(mode_o), 0);
    check("R1 base after reset", 64'(pt_base_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    do_write(3'd0, 64'h1);
    do_write(3'd1, 64'h1);
    do_write(3'd0, 64'h3);
    check("R1 enable cleared by reset", 64'(mode_o), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule